// File: doc/BRIEF.md
# Dual-Issue Dependency Check and Operand Bypass Control

This block is the issue controller of an in-order core with two symmetric execution pipelines that share one register bank (four read ports, two write ports). Each cycle an upstream decode stage presents a pair of decoded instructions: slot A, the older, and slot B, the younger. The block decides how many of them leave decode. It can issue both, only A, or neither. Slot A always goes to pipeline 0 and slot B to pipeline 1. It also tells the upstream how many slots it consumed, so that a held younger instruction moves into the older slot for the next cycle and is paired with the next fetched instruction.

For each of the four ALU operands it produces a bypass select. The select picks either the register bank or one of four forwarding sources. These sources are the results of the instructions issued one cycle earlier and two cycles earlier on each pipeline. The destinations of those four instructions are held inside the block. Every operand specifier of the pair is compared against all four, which takes sixteen comparators. A result is never bypassed between the two instructions of the same pair. A true dependency inside the pair splits it instead. A use of a load result one cycle after the load costs one stall cycle.

Top module: `dib_issue_ctl`

## Requirements
- R1: After reset no forwarding source is tracked. Every select reads 0 (register bank) until an instruction with a destination issues.
- R2: When `a_vld` is 1 and A has no load-use hazard (R8), `issue_a` is 1 and A goes to pipeline 0. Otherwise `issue_a` is 0.
- R3: When A writes a register (`a_wr`=1) and `a_dst` equals `b_rs1` or `b_rs2`, `issue_b` is 0 in that cycle.
- R4: `take_cnt` gives the number of slots consumed: 0, 1 (A only) or 2 (A and B). It never reads 3.
- R5: Select encoding is as follows. 0 is the register bank. 1 is the pipeline 0 instruction issued one cycle ago. 2 is the pipeline 1 instruction issued one cycle ago. 3 is the pipeline 0 instruction issued two cycles ago. 4 is the pipeline 1 instruction issued two cycles ago. A source is chosen when its destination equals the operand specifier.
- R6: When several sources match one operand, the more recent age wins. At equal age, pipeline 1 wins, because it holds the later instruction in program order.
- R7: An issued instruction with `*_wr`=0 never becomes a forwarding source.
- R8: When the source chosen for an operand (per R6) is a load (`*_load`=1) issued one cycle ago, the instruction owning that operand does not issue. If A is stalled, B does not issue either.
- R9: `issue_b` is never 1 unless `issue_a` is 1.
- R10: A pipeline that issues nothing in a cycle contributes no source for the following cycle. Its previous entry still ages into the two-cycle-old position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_vld | input | 1 | Older slot holds an instruction |
| a_wr | input | 1 | Older instruction writes a register |
| a_load | input | 1 | Older instruction is a load |
| a_dst | input | REG_AW | Older destination specifier |
| a_rs1 | input | REG_AW | Older first source specifier |
| a_rs2 | input | REG_AW | Older second source specifier |
| b_vld | input | 1 | Younger slot holds an instruction |
| b_wr | input | 1 | Younger instruction writes a register |
| b_load | input | 1 | Younger instruction is a load |
| b_dst | input | REG_AW | Younger destination specifier |
| b_rs1 | input | REG_AW | Younger first source specifier |
| b_rs2 | input | REG_AW | Younger second source specifier |
| issue_a | output | 1 | Older instruction issues to pipeline 0 |
| issue_b | output | 1 | Younger instruction issues to pipeline 1 |
| take_cnt | output | 2 | Slots consumed this cycle |
| sel_a1 | output | 3 | Bypass select, older first operand |
| sel_a2 | output | 3 | Bypass select, older second operand |
| sel_b1 | output | 3 | Bypass select, younger first operand |
| sel_b2 | output | 3 | Bypass select, younger second operand |

## Verification
In a single cycle, the pair-splitting check and the load-use stall can both act on the younger instruction. That same cycle can also carry a bypass priority decision between the two pipelines.

The bench provokes this with a register space of only four entries. Destinations collide with sources constantly, so splits, stalls and multi-source matches occur together many times. Per cycle, the issue decisions, consumed count and all four selects are judged against a model the bench builds from the requirements, with its own history of what was issued.

// File: rtl/dib_pkg.sv
package dib_pkg;
    localparam int N_PIPES = 2;
    localparam int N_OPS   = 4;

    typedef enum logic [2:0] {
        FW_BANK  = 3'd0,
        FW_P0_N1 = 3'd1,
        FW_P1_N1 = 3'd2,
        FW_P0_N2 = 3'd3,
        FW_P1_N2 = 3'd4
    } fwd_src_e;
endpackage

// File: rtl/dib_track.sv
module dib_track #(
    parameter int AW = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  iss,
    input  logic [1:0]                  wr,
    input  logic [1:0]                  ld,
    input  logic [1:0][AW-1:0]          dst,
    output logic [1:0]                  n1_v,
    output logic [1:0]                  n1_ld,
    output logic [1:0][AW-1:0]          n1_dst,
    output logic [1:0]                  n2_v,
    output logic [1:0][AW-1:0]          n2_dst
);
    typedef struct packed {
        logic [1:0]         v1;
        logic [1:0]         ld1;
        logic [1:0][AW-1:0] d1;
        logic [1:0]         v2;
        logic [1:0][AW-1:0] d2;
    } hist_t;

    hist_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int p = 0; p < 2; p++) begin
            st_d.v1[p]  = iss[p] && wr[p];
            st_d.ld1[p] = ld[p];
            st_d.d1[p]  = dst[p];
            st_d.v2[p]  = st_q.v1[p];
            st_d.d2[p]  = st_q.d1[p];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign n1_v   = st_q.v1;
    assign n1_ld  = st_q.ld1;
    assign n1_dst = st_q.d1;
    assign n2_v   = st_q.v2;
    assign n2_dst = st_q.d2;
endmodule

// File: rtl/dib_fwd_pick.sv
module dib_fwd_pick
    import dib_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0]         src,
    input  logic [1:0]            n1_v,
    input  logic [1:0]            n1_ld,
    input  logic [1:0][AW-1:0]    n1_dst,
    input  logic [1:0]            n2_v,
    input  logic [1:0][AW-1:0]    n2_dst,
    output fwd_src_e              sel,
    output logic                  ld_hit
);
    logic [1:0] hit1, hit2;

    for (genvar p = 0; p < 2; p++) begin : g_cmp
        assign hit1[p] = n1_v[p] && (n1_dst[p] == src);
        assign hit2[p] = n2_v[p] && (n2_dst[p] == src);
    end

    // Newer age first, then pipeline 1 (later in program order) first.
    always_comb begin
        sel    = FW_BANK;
        ld_hit = 1'b0;
        if (hit1[1]) begin
            sel    = FW_P1_N1;
            ld_hit = n1_ld[1];
        end else if (hit1[0]) begin
            sel    = FW_P0_N1;
            ld_hit = n1_ld[0];
        end else if (hit2[1]) begin
            sel    = FW_P1_N2;
        end else if (hit2[0]) begin
            sel    = FW_P0_N2;
        end
    end
endmodule

// File: rtl/dib_pair_hazard.sv
module dib_pair_hazard #(
    parameter int AW = 5
) (
    input  logic          a_vld,
    input  logic          a_wr,
    input  logic [AW-1:0] a_dst,
    input  logic          a_lu,
    input  logic          b_vld,
    input  logic [AW-1:0] b_rs1,
    input  logic [AW-1:0] b_rs2,
    input  logic          b_lu,
    output logic          iss_a,
    output logic          iss_b,
    output logic [1:0]    take
);
    logic pair_raw;

    always_comb begin
        pair_raw = a_wr && ((a_dst == b_rs1) || (a_dst == b_rs2));
        iss_a    = a_vld && !a_lu;
        iss_b    = iss_a && b_vld && !pair_raw && !b_lu;
        take     = {iss_b, iss_a && !iss_b};
    end
endmodule

// File: rtl/dib_issue_ctl.sv
module dib_issue_ctl
    import dib_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_vld,
    input  logic              a_wr,
    input  logic              a_load,
    input  logic [REG_AW-1:0] a_dst,
    input  logic [REG_AW-1:0] a_rs1,
    input  logic [REG_AW-1:0] a_rs2,
    input  logic              b_vld,
    input  logic              b_wr,
    input  logic              b_load,
    input  logic [REG_AW-1:0] b_dst,
    input  logic [REG_AW-1:0] b_rs1,
    input  logic [REG_AW-1:0] b_rs2,
    output logic              issue_a,
    output logic              issue_b,
    output logic [1:0]        take_cnt,
    output logic [2:0]        sel_a1,
    output logic [2:0]        sel_a2,
    output logic [2:0]        sel_b1,
    output logic [2:0]        sel_b2
);
    logic [1:0]                n1_v, n1_ld, n2_v;
    logic [1:0][REG_AW-1:0]    n1_dst, n2_dst;
    logic [N_OPS-1:0][REG_AW-1:0] op_src;
    fwd_src_e                  op_sel [N_OPS];
    logic [N_OPS-1:0]          op_lu;
    logic                      iss_a, iss_b;
    logic [1:0]                take;

    assign op_src = {b_rs2, b_rs1, a_rs2, a_rs1};

    for (genvar k = 0; k < N_OPS; k++) begin : g_op
        dib_fwd_pick #(.AW(REG_AW)) u_pick (
            .src    (op_src[k]),
            .n1_v   (n1_v),
            .n1_ld  (n1_ld),
            .n1_dst (n1_dst),
            .n2_v   (n2_v),
            .n2_dst (n2_dst),
            .sel    (op_sel[k]),
            .ld_hit (op_lu[k])
        );
    end

    dib_pair_hazard #(.AW(REG_AW)) u_haz (
        .a_vld (a_vld),
        .a_wr  (a_wr),
        .a_dst (a_dst),
        .a_lu  (op_lu[0] || op_lu[1]),
        .b_vld (b_vld),
        .b_rs1 (b_rs1),
        .b_rs2 (b_rs2),
        .b_lu  (op_lu[2] || op_lu[3]),
        .iss_a (iss_a),
        .iss_b (iss_b),
        .take  (take)
    );

    dib_track #(.AW(REG_AW)) u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .iss    ({iss_b, iss_a}),
        .wr     ({b_wr, a_wr}),
        .ld     ({b_load, a_load}),
        .dst    ({b_dst, a_dst}),
        .n1_v   (n1_v),
        .n1_ld  (n1_ld),
        .n1_dst (n1_dst),
        .n2_v   (n2_v),
        .n2_dst (n2_dst)
    );

    assign issue_a  = iss_a;
    assign issue_b  = iss_b;
    assign take_cnt = take;
    assign sel_a1   = op_sel[0];
    assign sel_a2   = op_sel[1];
    assign sel_b1   = op_sel[2];
    assign sel_b2   = op_sel[3];
endmodule

// File: rtl/dib_issue_ctl_chk.sv
module dib_issue_ctl_chk #(
    parameter int REG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_vld,
    input logic              a_wr,
    input logic              a_load,
    input logic [REG_AW-1:0] a_dst,
    input logic [REG_AW-1:0] b_rs1,
    input logic [REG_AW-1:0] b_rs2,
    input logic              issue_a,
    input logic              issue_b,
    input logic [1:0]        take_cnt,
    input logic [2:0]        sel_a1,
    input logic [2:0]        sel_a2,
    input logic [2:0]        sel_b1,
    input logic [2:0]        sel_b2
);
    p_b_needs_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
        issue_b |-> issue_a);

    p_pair_raw_split_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_b && a_wr) |-> (a_dst != b_rs1 && a_dst != b_rs2));

    p_take_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take_cnt != 2'd3);

    p_sel_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_a1 <= 3'd4 && sel_a2 <= 3'd4 && sel_b1 <= 3'd4 && sel_b2 <= 3'd4);

    p_bubble_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_a |=> (sel_a1 != 3'd1 && sel_a1 != 3'd2 &&
                      sel_b2 != 3'd1 && sel_b2 != 3'd2));

    p_single_no_p1_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_a && !issue_b) |=> (sel_a1 != 3'd2 && sel_a2 != 3'd2 &&
                                   sel_b1 != 3'd2 && sel_b2 != 3'd2));

    p_no_dst_no_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_a && !issue_b && !a_wr) |=> (sel_a1 != 3'd1 && sel_a2 != 3'd1));

    p_load_use_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_a && !issue_b && a_wr && a_load) |=>
            (!issue_a || (sel_a1 != 3'd1 && sel_a2 != 3'd1)));
endmodule

bind dib_issue_ctl dib_issue_ctl_chk #(.REG_AW(REG_AW)) u_chk (.*);

// File: tb/dib_issue_ctl_tb.sv
`timescale 1ns/1ps
module dib_issue_ctl_tb;
    localparam int AW = 2;
    localparam int N_CYC = 4000;

    typedef struct packed {
        logic v, wr, ld;
        logic [AW-1:0] dst, rs1, rs2;
    } ins_t;

    typedef struct packed {
        logic v, ld;
        logic [AW-1:0] dst;
    } ent_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic a_vld, a_wr, a_load, b_vld, b_wr, b_load;
    logic [AW-1:0] a_dst, a_rs1, a_rs2, b_dst, b_rs1, b_rs2;
    logic issue_a, issue_b;
    logic [1:0] take_cnt;
    logic [2:0] sel_a1, sel_a2, sel_b1, sel_b2;

    dib_issue_ctl #(.REG_AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_vld(a_vld), .a_wr(a_wr), .a_load(a_load),
        .a_dst(a_dst), .a_rs1(a_rs1), .a_rs2(a_rs2),
        .b_vld(b_vld), .b_wr(b_wr), .b_load(b_load),
        .b_dst(b_dst), .b_rs1(b_rs1), .b_rs2(b_rs2),
        .issue_a(issue_a), .issue_b(issue_b), .take_cnt(take_cnt),
        .sel_a1(sel_a1), .sel_a2(sel_a2), .sel_b1(sel_b1), .sel_b2(sel_b2)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    logic [31:0] rng = 32'h1234_5677;
    ent_t h1 [2];
    ent_t h2 [2];
    ins_t cur_a, cur_b;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic gen(output ins_t i);
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        i.v   = (rng[2:0] != 3'd0);
        i.wr  = (rng[4:3] != 2'd0);
        i.ld  = i.wr && (rng[6:5] == 2'd0);
        i.dst = rng[8 +: AW];
        i.rs1 = rng[12 +: AW];
        i.rs2 = rng[16 +: AW];
    endtask

    // Bench model of R5/R6/R8: returns select code, sets lu on load winner at age one.
    function automatic int pick(input logic [AW-1:0] s, output bit lu);
        lu = 0;
        if (h1[1].v && h1[1].dst == s) begin lu = h1[1].ld; return 2; end
        if (h1[0].v && h1[0].dst == s) begin lu = h1[0].ld; return 1; end
        if (h2[1].v && h2[1].dst == s) return 4;
        if (h2[0].v && h2[0].dst == s) return 3;
        return 0;
    endfunction

    task automatic drive(input ins_t a, input ins_t b);
        a_vld = a.v; a_wr = a.wr; a_load = a.ld;
        a_dst = a.dst; a_rs1 = a.rs1; a_rs2 = a.rs2;
        b_vld = b.v; b_wr = b.wr; b_load = b.ld;
        b_dst = b.dst; b_rs1 = b.rs1; b_rs2 = b.rs2;
    endtask

    task automatic step();
        bit l1, l2, l3, l4, ea, eb, raw;
        int s1, s2, s3, s4, et;
        @(negedge clk);
        drive(cur_a, cur_b);
        #1;
        s1 = pick(cur_a.rs1, l1);
        s2 = pick(cur_a.rs2, l2);
        s3 = pick(cur_b.rs1, l3);
        s4 = pick(cur_b.rs2, l4);
        raw = cur_a.wr && (cur_a.dst == cur_b.rs1 || cur_a.dst == cur_b.rs2);
        ea = cur_a.v && !l1 && !l2;
        eb = ea && cur_b.v && !raw && !l3 && !l4;
        et = int'(ea) + int'(eb);
        chk("R2 R8 issue_a", issue_a, ea);
        chk("R3 R8 R9 issue_b", issue_b, eb);
        chk("R4 take_cnt", take_cnt, et);
        chk("R5 R6 R7 R10 sel_a1", sel_a1, s1);
        chk("R5 R6 R7 R10 sel_a2", sel_a2, s2);
        chk("R5 R6 R7 R10 sel_b1", sel_b1, s3);
        chk("R5 R6 R7 R10 sel_b2", sel_b2, s4);
        // history seen from the next cycle
        h2[0] = h1[0];
        h2[1] = h1[1];
        h1[0] = '{v: ea && cur_a.wr, ld: cur_a.ld, dst: cur_a.dst};
        h1[1] = '{v: eb && cur_b.wr, ld: cur_b.ld, dst: cur_b.dst};
        // upstream queue: held younger moves into the older slot (R4)
        if (!cur_a.v || et == 2) begin
            gen(cur_a); gen(cur_b);
        end else if (et == 1) begin
            if (cur_b.v) cur_a = cur_b; else gen(cur_a);
            gen(cur_b);
        end
    endtask

    initial begin
        ins_t z;
        z = '0;
        for (int p = 0; p < 2; p++) begin h1[p] = '0; h2[p] = '0; end
        drive(z, z);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: empty history, operands all equal register 0
        #1;
        chk("R1 issue_a", issue_a, 0);
        chk("R1 issue_b", issue_b, 0);
        chk("R1 take_cnt", take_cnt, 0);
        chk("R1 sel_a1", sel_a1, 0);
        chk("R1 sel_b2", sel_b2, 0);
        gen(cur_a); gen(cur_b);
        for (int c = 0; c < N_CYC; c++) step();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(100000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule